// File: doc/BRIEF.md
# ATA PIO Identify-Device Sequencer

This block is the host-side controller that fetches the 512-byte identification block from an ATA disk in programmed-I/O mode. It does not toggle the disk cable itself. It issues single register accesses (a 3-bit task-file address, a read or write request and 16-bit write data) to a separate bus-timing layer. That layer completes each access by pulsing an acknowledge, with read data valid in the same cycle.

A one-cycle `start` pulse begins a run. The sequencer:

1. polls the status register until the drive is no longer busy;
2. selects device 0;
3. polls until the drive is not busy and reports itself ready;
4. issues the identify command;
5. polls until the drive has finished working on the command;
6. reads the 256 data words, but only once the drive raises its data-request flag.

Every status read is preceded by a programmable quiet interval, so a fast host never samples status that the drive has not yet updated. Each wait stage has its own cycle budget. When a budget runs out, the run ends with a timeout code that names the stage, so a missing data request is reported rather than answered with a stream of garbage reads. Each data word is streamed out on a valid/data pair. The end of a run is marked by a one-cycle `done` with a result code.

Top module: `pioIdentifySeq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `regRd`, `regWr` and `wordValid` are all low.
- R2: After `start` in idle, the block reads status at address 7 repeatedly until a read returns bit 7 (busy) as 0. It performs no write before that.
- R3: After busy is seen clear, the block writes 0x00A0 to address 6, exactly once per run.
- R4: After the select write, the block polls status until bit 7 is 0 and bit 6 (ready) is 1. It then writes 0x00EC to address 7, exactly once per run.
- R5: After the command write, the block polls until bit 7 is 0. If that status has bit 0 (error) set, the run ends with result 1 (error) and no data read is made.
- R6: A read of address 0 (data) starts only in the cycle after a status read that returned bit 7 = 0 and bit 3 (data request) = 1. While bit 3 is 0, the block keeps polling status.
- R7: A successful run makes exactly 256 data reads. Each word appears on `wordData` with `wordValid` high for one cycle, in the cycle after its acknowledge, in read order.
- R8: Between the end of any access and the request of the next status read, at least `settleCycles` clock cycles pass with no request.
- R9: A wait stage that lasts `TIMEOUT_CYCLES` cycles ends the run with result 2 (timeout). `faultStage` then names the stage: 0 = initial busy wait, 1 = ready wait, 2 = command busy wait, 3 = data-request wait.
- R10: `done` is high for exactly one cycle per run. On success, `result` is 0 and `done` coincides with the 256th `wordValid`.
- R11: A `start` pulse while `busy` is high has no effect. The run continues and finishes exactly once.
- R12: `regRd` and `regWr` are never high together. A request, with its address, is held until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run from idle |
| settleCycles | input | SETTLE_W | Quiet cycles enforced before every status read |
| busy | output | 1 | High from start until the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 ok, 1 drive error, 2 timeout; valid with `done` |
| faultStage | output | 2 | Wait stage active at the end of the run |
| regAddr | output | 3 | Task-file register address of the current request |
| regRd | output | 1 | Read request, held until acknowledged |
| regWr | output | 1 | Write request, held until acknowledged |
| regWrData | output | 16 | Write data |
| regRdData | input | 16 | Read data, valid while `regAck` is high |
| regAck | input | 1 | One-cycle completion of the current access |
| wordValid | output | 1 | Identify word valid |
| wordData | output | 16 | Identify word |

## Verification
The assertions assume that the bus-timing layer behaves as follows:
- it acknowledges only while a request is pending;
- it gives one acknowledge per access;
- it presents read data in the acknowledge cycle.

The bench's behavioural drive model keeps to this. It counts a fixed latency of one to three cycles from each request, pulses `regAck` for a single cycle, and restarts its count for a request that stays high. Status values follow a per-run script of busy, not-ready and no-data-request counts, so every polling loop and every exit path, including the endless ones that must time out, is reached by legal traffic.

// File: rtl/pioIdentPkg.sv
package pioIdentPkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_ERR     = 2'd1,
    RES_TIMEOUT = 2'd2
  } resultT;

  typedef enum logic [1:0] {
    STG_IDLEBUSY = 2'd0,
    STG_READY    = 2'd1,
    STG_CMDBUSY  = 2'd2,
    STG_DRQ      = 2'd3
  } stageT;

  localparam logic [2:0] ADDR_DATA    = 3'd0;
  localparam logic [2:0] ADDR_DEVHEAD = 3'd6;
  localparam logic [2:0] ADDR_STATCMD = 3'd7;

  localparam logic [15:0] DEV_SELECT0  = 16'h00A0;
  localparam logic [15:0] CMD_IDENTIFY = 16'h00EC;

  // strobes from control to datapath
  typedef struct packed {
    logic settleLoad;
    logic toClear;
    logic wordClear;
    logic wordTake;
  } dpCtrlT;

endpackage

// File: rtl/pioIdentDatapath.sv
module pioIdentDatapath
  import pioIdentPkg::*;
#(
  parameter int SETTLE_W       = 8,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int WORDS          = 256,
  parameter int DATA_W         = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrlT              ctrl,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic [DATA_W-1:0]   regRdData,
  output logic                settleDone,
  output logic                toExpired,
  output logic                lastWord,
  output logic                wordValid,
  output logic [DATA_W-1:0]   wordData
);

  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int WC_W = $clog2(WORDS + 1);
  localparam logic [TO_W-1:0] TO_LIMIT  = TO_W'(TIMEOUT_CYCLES);
  localparam logic [WC_W-1:0] LAST_WORD = WC_W'(WORDS - 1);

  logic [SETTLE_W-1:0] settleCnt;
  logic [TO_W-1:0]     toCnt;
  logic [WC_W-1:0]     wordCnt;

  // settle interval: loaded on entry, drains to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                settleCnt <= '0;
    else if (ctrl.settleLoad) settleCnt <= settleCycles;
    else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
  end
  assign settleDone = (settleCnt == '0);

  // per-stage budget, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  toCnt <= '0;
    else if (ctrl.toClear)      toCnt <= '0;
    else if (toCnt != TO_LIMIT) toCnt <= toCnt + 1'b1;
  end
  assign toExpired = (toCnt == TO_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wordCnt <= '0;
    else if (ctrl.wordClear) wordCnt <= '0;
    else if (ctrl.wordTake)  wordCnt <= wordCnt + 1'b1;
  end
  assign lastWord = (wordCnt == LAST_WORD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordData  <= '0;
    end else begin
      wordValid <= ctrl.wordTake;
      if (ctrl.wordTake) wordData <= regRdData;
    end
  end

  AST_BUDGET_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    toExpired && !ctrl.toClear |=> toExpired);  // R9

  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wordTake |-> wordCnt < WC_W'(WORDS));  // R7

endmodule

// File: rtl/pioIdentCtrl.sv
module pioIdentCtrl
  import pioIdentPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        regAck,
  input  logic        statBsy,
  input  logic        statDrdy,
  input  logic        statDrq,
  input  logic        statErr,
  input  logic        settleDone,
  input  logic        toExpired,
  input  logic        lastWord,
  output dpCtrlT      ctrl,
  output logic [2:0]  regAddr,
  output logic        regRd,
  output logic        regWr,
  output logic [15:0] regWrData,
  output logic        busy,
  output logic        done,
  output resultT      result,
  output stageT       faultStage
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_POLL, ST_WDEV, ST_WCMD, ST_READ, ST_DONE
  } stateT;

  stateT  state, stateNext;
  stageT  stage, stageNext;
  resultT resQ, resNext;

  always_comb begin
    stateNext = state;
    stageNext = stage;
    resNext   = resQ;
    ctrl      = '0;
    regAddr   = ADDR_STATCMD;
    regRd     = 1'b0;
    regWr     = 1'b0;
    regWrData = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext       = ST_SETTLE;
          stageNext       = STG_IDLEBUSY;
          resNext         = RES_OK;
          ctrl.settleLoad = 1'b1;
          ctrl.toClear    = 1'b1;
          ctrl.wordClear  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (toExpired) begin
          stateNext = ST_DONE;
          resNext   = RES_TIMEOUT;
        end else if (settleDone) begin
          stateNext = ST_POLL;
        end
      end
      ST_POLL: begin
        regRd   = 1'b1;
        regAddr = ADDR_STATCMD;
        if (regAck) begin
          // default: retry after another settle interval
          stateNext       = ST_SETTLE;
          ctrl.settleLoad = 1'b1;
          unique case (stage)
            STG_IDLEBUSY: if (!statBsy) begin
              stateNext       = ST_WDEV;
              ctrl.settleLoad = 1'b0;
            end
            STG_READY: if (!statBsy && statDrdy) begin
              stateNext       = ST_WCMD;
              ctrl.settleLoad = 1'b0;
            end
            STG_CMDBUSY: if (!statBsy) begin
              if (statErr) begin
                stateNext       = ST_DONE;
                resNext         = RES_ERR;
                ctrl.settleLoad = 1'b0;
              end else if (statDrq) begin
                stateNext       = ST_READ;
                ctrl.settleLoad = 1'b0;
              end else begin
                stageNext    = STG_DRQ;
                ctrl.toClear = 1'b1;
              end
            end
            STG_DRQ: if (!statBsy) begin
              if (statErr) begin
                stateNext       = ST_DONE;
                resNext         = RES_ERR;
                ctrl.settleLoad = 1'b0;
              end else if (statDrq) begin
                stateNext       = ST_READ;
                ctrl.settleLoad = 1'b0;
              end
            end
            default: ;
          endcase
          if (stateNext == ST_SETTLE && !ctrl.toClear && toExpired) begin
            stateNext       = ST_DONE;
            resNext         = RES_TIMEOUT;
            ctrl.settleLoad = 1'b0;
          end
        end
      end
      ST_WDEV: begin
        regWr     = 1'b1;
        regAddr   = ADDR_DEVHEAD;
        regWrData = DEV_SELECT0;
        if (regAck) begin
          stateNext       = ST_SETTLE;
          stageNext       = STG_READY;
          ctrl.settleLoad = 1'b1;
          ctrl.toClear    = 1'b1;
        end
      end
      ST_WCMD: begin
        regWr     = 1'b1;
        regAddr   = ADDR_STATCMD;
        regWrData = CMD_IDENTIFY;
        if (regAck) begin
          stateNext       = ST_SETTLE;
          stageNext       = STG_CMDBUSY;
          ctrl.settleLoad = 1'b1;
          ctrl.toClear    = 1'b1;
        end
      end
      ST_READ: begin
        regRd   = 1'b1;
        regAddr = ADDR_DATA;
        if (regAck) begin
          ctrl.wordTake = 1'b1;
          if (lastWord) begin
            stateNext = ST_DONE;
            resNext   = RES_OK;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stage <= STG_IDLEBUSY;
      resQ  <= RES_OK;
    end else begin
      state <= stateNext;
      stage <= stageNext;
      resQ  <= resNext;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign result     = resQ;
  assign faultStage = stage;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && regWr));  // R12

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (regRd || regWr) && !regAck |=> (regRd || regWr) && $stable(regAddr));  // R12

  AST_DATA_AFTER_DRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRd && regAddr == ADDR_DATA) |->
      $past(regAck && regAddr == ADDR_STATCMD && statDrq && !statBsy));  // R6

  AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regAddr == ADDR_STATCMD |-> regWrData == CMD_IDENTIFY);  // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);  // R11

endmodule

// File: rtl/pioIdentifySeq.sv
module pioIdentifySeq
  import pioIdentPkg::*;
#(
  parameter int SETTLE_W       = 8,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int WORDS          = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                busy,
  output logic                done,
  output logic [1:0]          result,
  output logic [1:0]          faultStage,
  output logic [2:0]          regAddr,
  output logic                regRd,
  output logic                regWr,
  output logic [15:0]         regWrData,
  input  logic [15:0]         regRdData,
  input  logic                regAck,
  output logic                wordValid,
  output logic [15:0]         wordData
);

  localparam int DATA_W = 16;

  dpCtrlT ctrl;
  logic   settleDone, toExpired, lastWord;
  resultT resCode;
  stageT  stageCode;

  pioIdentCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .regAck     (regAck),
    .statBsy    (regRdData[7]),
    .statDrdy   (regRdData[6]),
    .statDrq    (regRdData[3]),
    .statErr    (regRdData[0]),
    .settleDone (settleDone),
    .toExpired  (toExpired),
    .lastWord   (lastWord),
    .ctrl       (ctrl),
    .regAddr    (regAddr),
    .regRd      (regRd),
    .regWr      (regWr),
    .regWrData  (regWrData),
    .busy       (busy),
    .done       (done),
    .result     (resCode),
    .faultStage (stageCode)
  );

  pioIdentDatapath #(
    .SETTLE_W       (SETTLE_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .WORDS          (WORDS),
    .DATA_W         (DATA_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .settleCycles (settleCycles),
    .regRdData    (regRdData),
    .settleDone   (settleDone),
    .toExpired    (toExpired),
    .lastWord     (lastWord),
    .wordValid    (wordValid),
    .wordData     (wordData)
  );

  assign result     = resCode;
  assign faultStage = stageCode;

endmodule

// File: tb/test_pioIdentifySeq.sv
`timescale 1ns/1ps
module test_pioIdentifySeq;

  localparam int TO = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  settleCycles = 8'd0;
  logic        busy, done, regRd, regWr, regAck = 1'b0, wordValid;
  logic [1:0]  result, faultStage;
  logic [2:0]  regAddr;
  logic [15:0] regWrData, wordData;
  logic [15:0] regRdData = 16'h0;

  always #2.5 clk = ~clk;

  pioIdentifySeq #(.SETTLE_W(8), .TIMEOUT_CYCLES(TO), .WORDS(256)) i_pioIdentifySeq (
    .clk(clk), .rstN(rstN), .start(start), .settleCycles(settleCycles),
    .busy(busy), .done(done), .result(result), .faultStage(faultStage),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .regAck(regAck), .wordValid(wordValid), .wordData(wordData)
  );

  int checks = 0;
  int errors = 0;

  // drive script, set by the stimulus before each start
  int preBusy = 0, notReady = 0, cmdBusy = 0, noDrq = 0, ackLat = 1;
  bit errMode = 0, neverDrq = 0, alwaysBusy = 0;

  // model observations
  int  phase = 0, pollCnt = 0, lat = 0, dataIdx = 0, wordsSeen = 0;
  int  reads0 = 0, reads1 = 0, reads2 = 0, devWrites = 0, cmdWrites = 0;
  int  badDevData = 0, badCmdData = 0, earlyWrites = 0, dataReads = 0;
  int  doneCnt = 0, idleRun = 1000;
  int  lastResult = 0, lastStage = 0;
  bit  drqShown = 0, prevReq = 0, prevAck = 0, prevDone = 0, lastDoneWithWord = 0;
  logic [2:0] prevAddr = 3'd0;

  function automatic logic [15:0] wordOf(int i);
    return 16'((i * 16'h0123) ^ 16'h5A5A);
  endfunction

  function automatic void check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  // reference drive model and per-clock checks, all at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      regAck = 1'b0; lat = 0; prevReq = 0; prevAck = 0; prevDone = 0;
    end else begin
      check(!(regRd && regWr), "R12", "rd and wr together", 1, 0);
      if (prevReq && !prevAck)
        check((regRd || regWr) && regAddr == prevAddr, "R12", "request dropped", regAddr, prevAddr);
      if ((regRd || regWr) && (!prevReq || prevAck) && regRd && regAddr == 3'd7) begin
        check(idleRun >= int'(settleCycles), "R8", "settle gap", idleRun, settleCycles);
      end
      if (regRd || regWr) idleRun = 0; else idleRun++;
      if (wordValid) begin
        check(wordData == wordOf(wordsSeen), "R7", "word value", wordData, wordOf(wordsSeen));
        wordsSeen++;
      end
      if (done) begin
        check(!prevDone, "R10", "done longer than one cycle", 1, 0);
        doneCnt++;
        lastResult = result;
        lastStage = faultStage;
        lastDoneWithWord = wordValid;
      end
      prevDone = done;
      prevReq  = regRd || regWr;
      prevAddr = regAddr;
      if (regAck) begin
        regAck = 1'b0; lat = 0;
      end else if (regRd || regWr) begin
        lat++;
        if (lat >= ackLat) begin
          regAck = 1'b1;
          if (regWr) begin
            if (regAddr == 3'd6) begin
              devWrites++; if (regWrData != 16'h00A0) badDevData++;
              if (phase != 0) earlyWrites++;
              phase = 1; pollCnt = 0; dataIdx = 0; wordsSeen = 0;
            end else if (regAddr == 3'd7) begin
              cmdWrites++; if (regWrData != 16'h00EC) badCmdData++;
              phase = 2; pollCnt = 0;
            end
          end else if (regAddr == 3'd7) begin
            logic [7:0] st;
            if (phase == 0) begin
              st = (alwaysBusy || pollCnt < preBusy) ? 8'h80 : 8'h40;
              reads0++;
            end else if (phase == 1) begin
              st = (pollCnt < notReady) ? 8'h00 : 8'h40;
              reads1++;
            end else begin
              if (pollCnt < cmdBusy) st = 8'h80;
              else if (errMode) st = 8'h41;
              else if (neverDrq || pollCnt < cmdBusy + noDrq) st = 8'h40;
              else st = 8'h48;
              reads2++;
            end
            pollCnt++;
            drqShown = st[3] && !st[7];
            regRdData = {8'h00, st};
          end else if (regAddr == 3'd0) begin
            check(drqShown, "R6", "data read without data request", 0, 1);
            dataReads++;
            regRdData = wordOf(dataIdx);
            dataIdx++;
          end
        end
      end
      prevAck = regAck;
    end
  end

  task automatic runScen(string nm, int pb, int nr, int cb, int nd, bit em, bit nv, bit ab,
                         int al, int sc, bit poke, int expRes, int expStage);
    int b0, b1, b2, bd, bc, bdr, bdone;
    preBusy = pb; notReady = nr; cmdBusy = cb; noDrq = nd; errMode = em;
    neverDrq = nv; alwaysBusy = ab; ackLat = al; settleCycles = 8'(sc);
    b0 = reads0; b1 = reads1; b2 = reads2; bd = devWrites; bc = cmdWrites;
    bdr = dataReads; bdone = doneCnt;
    phase = 0; pollCnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2", {nm, " busy after start"}, busy, 1);
    check(regWr == 1'b0, "R2", {nm, " no write before status"}, regWr, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (doneCnt == bdone) @(negedge clk);
    repeat (20) @(negedge clk);
    check(doneCnt - bdone == 1, "R11", {nm, " done count"}, doneCnt - bdone, 1);
    check(lastResult == expRes, "R9", {nm, " result"}, lastResult, expRes);
    check(busy == 1'b0, "R10", {nm, " idle after done"}, busy, 0);
    if (expRes == 2) check(lastStage == expStage, "R9", {nm, " fault stage"}, lastStage, expStage);
    check(earlyWrites == 0 && badDevData == 0, "R3", {nm, " select write"}, badDevData, 0);
    check(badCmdData == 0, "R4", {nm, " command code"}, badCmdData, 0);
    if (ab) begin
      check(devWrites == bd, "R2", {nm, " no select while busy"}, devWrites - bd, 0);
    end else begin
      check(reads0 - b0 == pb + 1, "R2", {nm, " busy polls"}, reads0 - b0, pb + 1);
      check(devWrites - bd == 1, "R3", {nm, " select count"}, devWrites - bd, 1);
      check(reads1 - b1 == nr + 1, "R4", {nm, " ready polls"}, reads1 - b1, nr + 1);
      check(cmdWrites - bc == 1, "R4", {nm, " command count"}, cmdWrites - bc, 1);
    end
    if (expRes == 0) begin
      check(reads2 - b2 == cb + nd + 1, "R6", {nm, " drq polls"}, reads2 - b2, cb + nd + 1);
      check(dataReads - bdr == 256, "R7", {nm, " data reads"}, dataReads - bdr, 256);
      check(wordsSeen == 256, "R7", {nm, " words streamed"}, wordsSeen, 256);
      check(lastDoneWithWord, "R10", {nm, " done with last word"}, lastDoneWithWord, 1);
    end else begin
      check(dataReads == bdr, "R5", {nm, " no data reads"}, dataReads - bdr, 0);
      if (em) check(reads2 - b2 == cb + 1, "R5", {nm, " polls before error"}, reads2 - b2, cb + 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !regRd && !regWr && !wordValid, "R1", "outputs in reset",
          {busy, done, regRd, regWr, wordValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !regRd && !regWr && !wordValid, "R1", "outputs after reset",
          {busy, done, regRd, regWr, wordValid}, 0);
    runScen("normal",   3, 2, 4, 3, 0, 0, 0, 1, 4, 0, 0, 0);
    runScen("nodelay",  0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 0);
    runScen("driveerr", 1, 1, 2, 0, 1, 0, 0, 2, 2, 0, 1, 0);
    runScen("nodrq",    0, 0, 1, 0, 0, 1, 0, 2, 4, 0, 2, 3);
    runScen("stuckbsy", 0, 0, 0, 0, 0, 0, 1, 2, 4, 0, 2, 0);
    runScen("restart",  2, 1, 3, 2, 0, 0, 0, 2, 6, 1, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule